// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

A register-controlled parallel I/O port with up to 32 pins. Software reaches it through a word-addressed register bus with separate read and write strobes. Each pin can be driven by the port or left as an input, and each pin can take part in a single interrupt output.

Pin inputs pass through a two-stage synchronizer. Software reads the synchronized pin levels. An edge detector compares the synchronized value with its value one cycle earlier. The interrupt trigger is chosen when the block is built and cannot be changed while it runs. The choices are rising edge, falling edge, either edge, or high level.

In the three edge modes, a detected edge sets a sticky capture bit. Software clears a capture bit by writing a 1 to it. The interrupt is raised while any unmasked capture bit is set. In level mode there is no capture: the interrupt follows the unmasked synchronized pin levels directly.

Top module: `pio_edge_port`

## Requirements
- R1: After reset, the output-data, direction, mask and capture registers are all zero: pin_oe is 0, pin_out is 0 and irq is 0.
- R2: Register word 1 is the direction register, where 1 means output. pin_oe equals the direction register, and pin_out equals the output-data register ANDed with it. A value written to the output-data register (word 0) while a pin is an input is kept and appears on the pin once the pin becomes an output.
- R3: A read of word 0 returns the pin inputs after two clock stages of synchronization. Bits at and above NPINS read as 0.
- R4: In an edge mode, a qualifying change of a synchronized pin sets that pin's bit in the capture register (word 3). Rising mode uses 0 to 1, falling mode uses 1 to 0, and both-edges mode uses either change. The TRIG encoding is 0 rising, 1 falling, 2 both, 3 level.
- R5: Writing word 3 clears every capture bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: If an edge on a pin arrives in the same cycle as a write that clears that pin's capture bit, the bit stays set.
- R7: In an edge mode, irq is 1 exactly when some capture bit and the matching bit of the mask register (word 2, 1 means enabled) are both 1.
- R8: In level mode, irq is the OR over all pins of the synchronized input ANDed with the mask, and the capture register reads 0.
- R9: Read data is registered. It appears the cycle after the read strobe is sampled and holds until the next read. The direction and mask registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word index: 0 data, 1 direction, 2 mask, 3 capture (byte offsets 0x0, 0x4, 0x8, 0xC) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The checker asserts on every cycle the following properties:
- pin_out never drives a pin whose output enable is 0.
- irq stays low while the mask is zero.
- A write-one clear leaves no cleared bit set unless an edge arrived in that cycle.
- A capture bit changes only on an edge or a clear.
- Read data holds between reads.

Only the bench's scenarios can show the rest, across four builds that differ in trigger mode:
- the exact pin values captured in each mode;
- the timing of a clear that collides with an edge;
- the synchronizer latency seen in data reads;
- the zeroed upper bits of a narrow port.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_o   <= '0;
            prev_o   <= '0;
        end else begin
            stage1_q <= din;
            sync_o   <= stage1_q;
            prev_o   <= sync_o;
        end
    end
endmodule

// File: rtl/pio_edge.sv
module pio_edge #(
    parameter int            W    = 32,
    parameter pio_pkg::trig_e TRIG = pio_pkg::TRIG_RISE
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    output logic [W-1:0] edge_o
);
    generate
        if (TRIG == pio_pkg::TRIG_RISE) begin : g_rise
            assign edge_o = cur & ~prev;
        end else if (TRIG == pio_pkg::TRIG_FALL) begin : g_fall
            assign edge_o = ~cur & prev;
        end else if (TRIG == pio_pkg::TRIG_BOTH) begin : g_both
            assign edge_o = cur ^ prev;
        end else begin : g_level
            assign edge_o = '0;
        end
    endgenerate
endmodule

// File: rtl/pio_regs.sv
module pio_regs #(
    parameter int W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [1:0]                addr,
    input  logic [pio_pkg::BUS_W-1:0] wdata,
    input  logic [W-1:0]              edge_i,
    output logic [W-1:0]              dout_q,
    output logic [W-1:0]              dir_q,
    output logic [W-1:0]              mask_q,
    output logic [W-1:0]              cap_q
);
    import pio_pkg::*;

    logic [W-1:0] clr_v;
    logic [W-1:0] cap_d;

    always_comb begin
        clr_v = (wr && sel_e'(addr) == SEL_CAP) ? wdata[W-1:0] : '0;
        cap_d = (cap_q & ~clr_v) | edge_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
            cap_q  <= '0;
        end else begin
            if (wr) begin
                unique case (sel_e'(addr))
                    SEL_DATA: dout_q <= wdata[W-1:0];
                    SEL_DIR:  dir_q  <= wdata[W-1:0];
                    SEL_MASK: mask_q <= wdata[W-1:0];
                    SEL_CAP:  ;
                endcase
            end
            cap_q <= cap_d;
        end
    end
endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port #(
    parameter int             NPINS = 32,
    parameter pio_pkg::trig_e TRIG  = pio_pkg::TRIG_RISE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [1:0]                bus_addr,
    input  logic [pio_pkg::BUS_W-1:0] bus_wdata,
    output logic [pio_pkg::BUS_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]          pin_in,
    output logic [NPINS-1:0]          pin_out,
    output logic [NPINS-1:0]          pin_oe,
    output logic                      irq
);
    import pio_pkg::*;

    logic [NPINS-1:0] sync_v, prev_v, edge_v;
    logic [NPINS-1:0] dout_q, dir_q, mask_q, cap_q;
    logic [BUS_W-1:0] rdata_d;

    pio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .sync_o(sync_v), .prev_o(prev_v)
    );

    pio_edge #(.W(NPINS), .TRIG(TRIG)) u_edge (
        .cur(sync_v), .prev(prev_v), .edge_o(edge_v)
    );

    pio_regs #(.W(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .edge_i(edge_v), .dout_q(dout_q), .dir_q(dir_q), .mask_q(mask_q), .cap_q(cap_q)
    );

    always_comb begin
        unique case (sel_e'(bus_addr))
            SEL_DATA: rdata_d = BUS_W'(sync_v);
            SEL_DIR:  rdata_d = BUS_W'(dir_q);
            SEL_MASK: rdata_d = BUS_W'(mask_q);
            SEL_CAP:  rdata_d = BUS_W'(cap_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rdata_d;
    end

    assign pin_oe  = dir_q;
    assign pin_out = dout_q & dir_q;

    generate
        if (TRIG == TRIG_LEVEL) begin : g_irq_level
            assign irq = |(sync_v & mask_q);
        end else begin : g_irq_edge
            assign irq = |(cap_q & mask_q);
        end
    endgenerate
endmodule

// File: rtl/pio_edge_port_chk.sv
module pio_edge_port_chk #(
    parameter int             NPINS = 32,
    parameter pio_pkg::trig_e TRIG  = pio_pkg::TRIG_RISE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] cap_q,
    input logic [NPINS-1:0] edge_v
);
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0)); // R2

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R9

    generate
        if (TRIG != pio_pkg::TRIG_LEVEL) begin : g_edge_chk
            AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == 2'd3) |=>
                ((cap_q & $past(bus_wdata[NPINS-1:0]) & ~$past(edge_v)) == '0)); // R5

            AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (|edge_v) |=> ((cap_q & $past(edge_v)) == $past(edge_v))); // R6

            AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!(|edge_v) && !(bus_wr && bus_addr == 2'd3)) |=> $stable(cap_q)); // R5
        end else begin : g_level_chk
            AST_LEVEL_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                (cap_q == '0)); // R8
        end
    endgenerate
endmodule

bind pio_edge_port pio_edge_port_chk #(.NPINS(NPINS), .TRIG(TRIG)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq), .mask_q(mask_q), .cap_q(cap_q), .edge_v(edge_v)
);

// File: tb/test_pio_edge_port.sv
module test_pio_edge_port;
    import pio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pins = '0;
    logic [31:0] rd0, rd1, rd2, rd3;
    logic [31:0] po0, oe0;
    logic [7:0]  po1, oe1, po2, oe2, po3, oe3;
    logic        irq0, irq1, irq2, irq3;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    typedef struct {
        logic [31:0] e0, e1, e2, e3;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;

    pio_edge_port #(.NPINS(32), .TRIG(TRIG_RISE)) i_pio_edge_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd0), .pin_in(pins), .pin_out(po0),
        .pin_oe(oe0), .irq(irq0));
    pio_edge_port #(.NPINS(8), .TRIG(TRIG_FALL)) i_pio_edge_port_fall (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd1), .pin_in(pins[7:0]), .pin_out(po1),
        .pin_oe(oe1), .irq(irq1));
    pio_edge_port #(.NPINS(8), .TRIG(TRIG_BOTH)) i_pio_edge_port_both (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd2), .pin_in(pins[7:0]), .pin_out(po2),
        .pin_oe(oe2), .irq(irq2));
    pio_edge_port #(.NPINS(8), .TRIG(TRIG_LEVEL)) i_pio_edge_port_lvl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd3), .pin_in(pins[7:0]), .pin_out(po3),
        .pin_oe(oe3), .irq(irq3));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [1:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, logic [31:0] x0, logic [31:0] x1,
                            logic [31:0] x2, logic [31:0] x3, string tag);
        item_t it;
        it.e0 = x0; it.e1 = x1; it.e2 = x2; it.e3 = x3; it.tag = tag;
        sbq.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(string tag, logic [3:0] exp);
        chk(tag, {28'd0, irq3, irq2, irq1, irq0}, {28'd0, exp});
    endtask

    // monitor: pop the expected item once the registered read data is out
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                item_t it;
                @(negedge clk);
                if (sbq.size() == 0) begin
                    chk({"unexpected read ", "R9"}, 32'd1, 32'd0);
                end else begin
                    it = sbq.pop_front();
                    chk({it.tag, " rise"}, rd0, it.e0);
                    chk({it.tag, " fall"}, rd1, it.e1);
                    chk({it.tag, " both"}, rd2, it.e2);
                    chk({it.tag, " level"}, rd3, it.e3);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 pin_oe", oe0, 32'd0);
        chk("R1 pin_out", po0, 32'd0);
        chk_irq("R1 irq", 4'b0000);
        bus_read(2'd1, 0, 0, 0, 0, "R1 dir");
        bus_read(2'd2, 0, 0, 0, 0, "R1 mask");
        bus_read(2'd3, 0, 0, 0, 0, "R1 cap");

        // R2 direction gating
        bus_write(2'd1, 32'h0000_FFFF);
        bus_write(2'd0, 32'hA5A5_A5A5);
        chk("R2 pin_oe", oe0, 32'h0000_FFFF);
        chk("R2 pin_out", po0, 32'h0000_A5A5);
        chk("R2 pin_out narrow", {24'd0, po1}, 32'h0000_00A5);
        bus_read(2'd1, 32'h0000_FFFF, 32'hFF, 32'hFF, 32'hFF, "R9 dir readback");

        // R3 synchronized readback, R4 rising capture, R7 masked irq
        pins = 32'h1234_5678;
        idle(4);
        chk_irq("R7 masked edges", 4'b0000);
        bus_read(2'd0, 32'h1234_5678, 32'h78, 32'h78, 32'h78, "R3 data");
        bus_read(2'd3, 32'h1234_5678, 32'h00, 32'h78, 32'h00, "R4 rise capture");

        bus_write(2'd2, 32'hFFFF_FFFF);
        chk_irq("R7 R8 unmasked", 4'b1101);
        bus_read(2'd2, 32'hFFFF_FFFF, 32'hFF, 32'hFF, 32'hFF, "R9 mask readback");

        // R5 write-one clear
        bus_write(2'd3, 32'h0000_0008);
        bus_read(2'd3, 32'h1234_5670, 32'h00, 32'h70, 32'h00, "R5 partial clear");
        bus_write(2'd3, 32'hFFFF_FFFF);
        chk_irq("R5 cleared irq", 4'b1000);

        // R4 falling capture, R8 level follows pins, R9 hold
        pins = 32'h0;
        idle(4);
        chk("R9 rdata held", rd0, 32'h1234_5670);
        chk_irq("R4 fall irq", 4'b0110);
        bus_read(2'd3, 32'h0, 32'h78, 32'h78, 32'h0, "R4 fall capture");
        bus_write(2'd3, 32'hFFFF_FFFF);

        // R6 edge coinciding with clear
        pins = 32'h1;
        idle(4);
        pins = 32'h0;
        idle(4);
        pins = 32'h1;
        idle(2);
        bus_write(2'd3, 32'h0000_0001);
        idle(1);
        bus_read(2'd3, 32'h1, 32'h0, 32'h1, 32'h0, "R6 edge wins");
        chk_irq("R6 R8 irq", 4'b1101);

        // R7 R8 mask off the active pin
        bus_write(2'd2, 32'h0000_0002);
        chk_irq("R7 R8 other pin masked", 4'b0000);

        // R2 data kept while input
        bus_write(2'd1, 32'h0);
        bus_write(2'd0, 32'h3C3C_3C3C);
        chk("R2 input not driven", po0, 32'h0);
        bus_write(2'd1, 32'hFFFF_FFFF);
        chk("R2 retained data", po0, 32'h3C3C_3C3C);
        chk("R2 retained narrow", {24'd0, po3}, 32'h3C);

        idle(3);
        finish_run();
    end
endmodule